// File: doc/BRIEF.md
# Ternary Order-Statistics Sorting Network

This block takes N ternary digits and returns all of their order statistics at once, from the smallest to the largest. Each digit travels on two wires. The sorting core is a triangular array of min/max cells with no feedback. Every cell is assembled from two conditional-swap primitives. A primitive copies its two control operands straight through. It also routes its two data operands either straight or crossed, depending on whether the first control is below the second.

Digits are inserted one at a time into an already ordered column, and adding digit k costs k-1 cells. Each wire feeds exactly one cell input, so the network needs N(N-1)/2 cells in total. The input code 11 is not a legal digit. When it is seen, every sorted output is forced to zero and a sticky flag is raised. An optional register stage, selected by a parameter, holds the result. The register stage has a synchronous active-high reset.

Top module: `tern_order_stat`

## Requirements
- R1: A digit is coded on two bits as 00 for 0, 01 for 1 and 10 for 2. Input digit i sits in `din[2i+1:2i]` and output slot i sits in `dout[2i+1:2i]`.
- R2: When every input code is legal, the output slots hold the same multiset of digits as the inputs, in non-decreasing order from slot 0 upward.
- R3: Slot 0 carries the smallest input digit and slot N-1 carries the largest.
- R4: With REG_OUT = 1, the result for the input present at a rising clock edge appears on `dout` after that edge. While `rst` is high at an edge, `dout` becomes all zeros and `bad_seen` becomes 0.
- R5: If any input carries the code 11, every output slot of that result is 0.
- R6: `bad_seen` rises at the first clock edge at which any input is 11 and `rst` is low. It stays high until a reset. When an illegal code and `rst` coincide at an edge, the reset wins and the flag stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for the output stage and the flag |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 2*N | N packed two-bit digits, digit i at bits 2i+1:2i |
| dout | output | 2*N | N packed sorted digits, slot 0 is the minimum |
| bad_seen | output | 1 | Sticky indication that an illegal code 11 has arrived |

## Verification
Illegal-code handling and reset can act on the same clock edge. The bench provokes this by holding `rst` high while an input carries 11. It then expects zeroed outputs and a flag that stays clear, followed by a clean sorted result once reset is released. Sorting and flagging also overlap. A legal vector applied right after an illegal one must sort correctly while the flag remains set. The reference model computes each expected vector by counting digit values, with no use of a network.

// File: rtl/tern_pkg.sv
package tern_pkg;
  typedef logic [1:0] trit_t;

  localparam trit_t TRIT_ZERO = 2'b00;
  localparam trit_t TRIT_ONE  = 2'b01;
  localparam trit_t TRIT_TWO  = 2'b10;
  localparam trit_t TRIT_BAD  = 2'b11;

  function automatic logic trit_below(input trit_t lhs, input trit_t rhs);
    return lhs < rhs;
  endfunction
endpackage

// File: rtl/tern_cswap.sv
module tern_cswap
  import tern_pkg::*;
(
  input  trit_t ctl_a,
  input  trit_t ctl_b,
  input  trit_t dat_c,
  input  trit_t dat_d,
  output trit_t thru_a,
  output trit_t thru_b,
  output trit_t out_r,
  output trit_t out_s
);
  logic straight;

  assign straight = trit_below(ctl_a, ctl_b);
  assign thru_a   = ctl_a;
  assign thru_b   = ctl_b;
  assign out_r    = straight ? dat_c : dat_d;
  assign out_s    = straight ? dat_d : dat_c;
endmodule

// File: rtl/tern_minmax_cell.sv
module tern_minmax_cell
  import tern_pkg::*;
(
  input  trit_t x,
  input  trit_t y,
  output trit_t lo,
  output trit_t hi
);
  trit_t x_copy, y_copy, sel_tag;
  trit_t unused_s1, unused_p2, unused_q2;

  // First swap: the copies of x and y go on, and sel_tag is 2 when x < y, else 0.
  tern_cswap u_sel (
    .ctl_a (x),       .ctl_b (y),
    .dat_c (TRIT_TWO), .dat_d (TRIT_ZERO),
    .thru_a(x_copy),  .thru_b(y_copy),
    .out_r (sel_tag), .out_s (unused_s1)
  );

  // Second swap: sel_tag < 1 means x >= y, so x goes out on hi.
  tern_cswap u_route (
    .ctl_a (sel_tag),   .ctl_b (TRIT_ONE),
    .dat_c (x_copy),    .dat_d (y_copy),
    .thru_a(unused_p2), .thru_b(unused_q2),
    .out_r (hi),        .out_s (lo)
  );

  always_comb a_r2_cell_order: assert (lo <= hi);
endmodule

// File: rtl/tern_sort_tri.sv
module tern_sort_tri
  import tern_pkg::*;
#(
  parameter int N = 4
) (
  input  trit_t vals   [N],
  output trit_t sorted [N]
);
  // Stage k holds the first k+1 inputs in ascending order.
  for (genvar k = 0; k < N; k++) begin : stg
    trit_t srt [k+1];
    if (k == 0) begin : seed
      assign srt[0] = vals[0];
    end else begin : ins
      trit_t car [k];
      for (genvar j = 0; j < k; j++) begin : cel
        trit_t a_in;
        if (j == k - 1) begin : top_in
          assign a_in = vals[k];
        end else begin : chain_in
          assign a_in = car[j+1];
        end
        tern_minmax_cell u_cell (
          .x (a_in),
          .y (stg[k-1].srt[j]),
          .lo(car[j]),
          .hi(srt[j+1])
        );
      end
      assign srt[0] = car[0];
    end
  end

  for (genvar i = 0; i < N; i++) begin : outs
    assign sorted[i] = stg[N-1].srt[i];
  end
endmodule

// File: rtl/tern_order_stat.sv
module tern_order_stat
  import tern_pkg::*;
#(
  parameter int N       = 4,
  parameter bit REG_OUT = 1'b1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [2*N-1:0] din,
  output logic [2*N-1:0] dout,
  output logic           bad_seen
);
  localparam int W = 2 * N;

  trit_t          clean  [N];
  trit_t          sorted [N];
  logic [N-1:0]   bad;
  logic           any_bad;
  logic [W-1:0]   result;
  logic           flag_q;

  for (genvar i = 0; i < N; i++) begin : san
    assign bad[i]   = (din[2*i +: 2] == TRIT_BAD);
    assign clean[i] = bad[i] ? TRIT_ZERO : trit_t'(din[2*i +: 2]);
    assign result[2*i +: 2] = any_bad ? TRIT_ZERO : sorted[i];
  end
  assign any_bad = |bad;

  tern_sort_tri #(.N(N)) u_net (
    .vals  (clean),
    .sorted(sorted)
  );

  if (REG_OUT) begin : g_reg
    logic [W-1:0] dout_q;
    always_ff @(posedge clk) begin
      if (rst) dout_q <= '0;
      else     dout_q <= result;
    end
    assign dout = dout_q;
  end else begin : g_comb
    assign dout = result;
  end

  always_ff @(posedge clk) begin
    if (rst)          flag_q <= 1'b0;
    else if (any_bad) flag_q <= 1'b1;
  end
  assign bad_seen = flag_q;

  // Observation wires for the checks, derived straight from the ports.
  function automatic trit_t vec_min(input logic [W-1:0] v);
    trit_t m = TRIT_TWO;
    for (int i = 0; i < N; i++) if (v[2*i +: 2] < m) m = v[2*i +: 2];
    return m;
  endfunction

  function automatic trit_t vec_max(input logic [W-1:0] v);
    trit_t m = TRIT_ZERO;
    for (int i = 0; i < N; i++) if (v[2*i +: 2] > m) m = v[2*i +: 2];
    return m;
  endfunction

  function automatic logic vec_ordered(input logic [W-1:0] v);
    logic ok = 1'b1;
    for (int i = 1; i < N; i++) if (v[2*i +: 2] < v[2*(i-1) +: 2]) ok = 1'b0;
    return ok;
  endfunction

  trit_t in_min, in_max;
  logic  out_ordered;
  assign in_min      = vec_min(din);
  assign in_max      = vec_max(din);
  assign out_ordered = vec_ordered(dout);

  a_r2_ordered: assert property (@(posedge clk) disable iff (rst) out_ordered);
  a_r6_sticky:  assert property (@(posedge clk) disable iff (rst) bad_seen |=> bad_seen);
  a_r6_set:     assert property (@(posedge clk) disable iff (rst) any_bad |=> bad_seen);

  if (REG_OUT) begin : g_chk
    a_r4_reset_clear: assert property (@(posedge clk) rst |=> (dout == '0 && !bad_seen));
    a_r5_zeroed:  assert property (@(posedge clk) disable iff (rst) any_bad |=> (dout == '0));
    a_r3_min:     assert property (@(posedge clk) disable iff (rst)
                    !any_bad |=> (dout[1:0] == $past(in_min)));
    a_r3_max:     assert property (@(posedge clk) disable iff (rst)
                    !any_bad |=> (dout[W-1 -: 2] == $past(in_max)));
  end
endmodule

// File: tb/tern_order_stat_bench.sv
module tern_order_stat_bench;
  localparam int N = 4;
  localparam int W = 2 * N;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] din = '0;
  logic [W-1:0] dout;
  logic         bad_seen;
  int           errors = 0;
  int           checks = 0;
  bit           done = 1'b0;

  always #10 clk = ~clk;

  tern_order_stat #(.N(N), .REG_OUT(1'b1)) u_tern_order_stat (
    .clk(clk), .rst(rst), .din(din), .dout(dout), .bad_seen(bad_seen)
  );

  // Reference: count how often each digit value occurs, then emit the values in order.
  function automatic logic [W-1:0] ref_sort(input logic [W-1:0] v);
    int cnt [3] = '{0, 0, 0};
    int idx = 0;
    logic [W-1:0] r = '0;
    for (int i = 0; i < N; i++) begin
      if (v[2*i +: 2] == 2'b11) return '0;
      cnt[v[2*i +: 2]]++;
    end
    for (int val = 0; val < 3; val++)
      for (int c = 0; c < cnt[val]; c++) begin
        r[2*idx +: 2] = 2'(val);
        idx++;
      end
    return r;
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // Drive at a falling edge, let one rising edge pass, then sample at the next falling edge.
  task automatic step(input logic [W-1:0] v, input logic r, input logic exp_flag, input string req);
    din = v;
    rst = r;
    @(posedge clk);
    @(negedge clk);
    check(req, dout, r ? '0 : ref_sort(v));
    check({req, " flag"}, W'(bad_seen), W'(exp_flag));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R4 reset dout", dout, '0);
    check("R4 reset flag", W'(bad_seen), '0);

    // R1: explicit coding 2,1,0,2 gives 0,1,2,2.
    step({2'b10, 2'b00, 2'b01, 2'b10}, 1'b0, 1'b0, "R1 coding");
    check("R1 slot values", dout, {2'b10, 2'b10, 2'b01, 2'b00});

    // R2 R3: every one of the 81 legal vectors.
    for (int code = 0; code < 81; code++) begin
      logic [W-1:0] v = '0;
      int t = code;
      for (int i = 0; i < N; i++) begin
        v[2*i +: 2] = 2'(t % 3);
        t = t / 3;
      end
      step(v, 1'b0, 1'b0, "R2 R3 sweep");
    end

    // R5: an illegal code zeroes the result, and R6 sets the flag.
    step({2'b01, 2'b11, 2'b10, 2'b00}, 1'b0, 1'b1, "R5 R6 illegal");
    step({2'b00, 2'b10, 2'b01, 2'b10}, 1'b0, 1'b1, "R6 sticky");
    step({2'b11, 2'b11, 2'b11, 2'b11}, 1'b0, 1'b1, "R5 all illegal");
    // R6: reset wins over an illegal code at the same edge.
    step({2'b11, 2'b01, 2'b00, 2'b10}, 1'b1, 1'b0, "R6 reset priority");
    step({2'b10, 2'b10, 2'b01, 2'b01}, 1'b0, 1'b0, "R4 after reset");
    step({2'b00, 2'b00, 2'b00, 2'b10}, 1'b0, 1'b0, "R3 single max");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule